// File: doc/BRIEF.md
# USB Endpoint and Core Event Interrupt Wrapper

This block sits beside a USB on-the-go controller and gathers its event pulses into two register groups: one for per-endpoint transfer events (transmit and receive), one for controller-level events. Each group keeps a sticky source word and an enable word. The host changes these only through separate set and clear aliases, so one write never disturbs bits it does not name. A read-only masked view shows which enabled events are waiting.

A single level interrupt output is raised whenever something is waiting and the output is armed. Raising the output disarms it. After service, the line stays low until the host writes the end-of-interrupt register, with any data, to re-arm it. The block also has a fixed revision word, a self-clearing soft reset in the control register, and a status word that mirrors the level of the controller's VBUS-drive signal.

Top module: `usb_irq_wrap`

## Requirements
- R1: After reset every source and enable word reads zero and `irq_o` is low. The revision word at 0x00 reads 32'h0002_0001.
- R2: Writing to a source-set alias (endpoint 0x24, core 0x44) raises every source bit written as one. Bits written as zero keep their value.
- R3: Writing to a source-clear alias (endpoint 0x28, core 0x2C+0x1C = 0x48) drops every source bit written as one and leaves the rest.
- R4: The enable words (endpoint 0x2C, core 0x4C) change only through their set aliases (0x30, 0x50) and clear aliases (0x34, 0x54), with one-bits acting.
- R5: The masked words (endpoint 0x38, core 0x58) read as source AND enable for their group.
- R6: In the endpoint word, bits 15:0 are transmit endpoints 0..15 and bits 31:17 are receive endpoints 1..15. Bit 16 always reads zero, whatever is written or pulsed on `ep_rx_evt[0]`.
- R7: In the core word, event i sits at bit 16+i for i = 0..8, and event 8 is the VBUS-drive event at bit 24. All other core bits read zero.
- R8: A one-cycle pulse on an event input sets the matching source bit at that clock edge. When a host clear hits the same bit in the same cycle, the bit still ends up set.
- R9: `irq_o` rises one clock after an armed block sees a non-zero masked word. It stays high while any masked word is non-zero. Once low, it does not rise again until a write to 0x60 with any data re-arms the block.
- R10: Writing one to control bit 0 (0x04) clears all source and enable bits at that edge and re-arms the block. Control reads back zero.
- R11: The status word at 0x08 reads `vbus_drv_lvl` in bit 0 and zero in every other bit.
- R12: Reserved offsets (0x10, 0x5C and any offset not listed) read zero and ignore writes. Direct writes to the source, enable and masked words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ep_tx_evt | input | 16 | Transmit endpoint event pulses, endpoint 0..15 |
| ep_rx_evt | input | 16 | Receive endpoint event pulses; bit 0 is unused |
| core_evt | input | 9 | Controller event pulses; bit 8 is the VBUS-drive event |
| vbus_drv_lvl | input | 1 | Current VBUS-drive level from the controller |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two things can land on the same edge. A hardware event pulse and a host write to the source-clear alias can hit the same bit, and the bench drives both together in one cycle. It then judges the result by reading the raw source word, where the bit must still be set. End-of-interrupt and a new firing can also coincide. The bench checks the re-arm path on its own: it confirms the line stays low while events are pending but unacknowledged, and that it returns exactly one clock after the end-of-interrupt write.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  typedef logic [31:0] word_t;

  localparam logic [7:0] OFS_REV       = 8'h00;
  localparam logic [7:0] OFS_CTRL      = 8'h04;
  localparam logic [7:0] OFS_STAT      = 8'h08;
  localparam logic [7:0] OFS_EP_SRC    = 8'h20;
  localparam logic [7:0] OFS_EP_SSET   = 8'h24;
  localparam logic [7:0] OFS_EP_SCLR   = 8'h28;
  localparam logic [7:0] OFS_EP_MSK    = 8'h2C;
  localparam logic [7:0] OFS_EP_MSET   = 8'h30;
  localparam logic [7:0] OFS_EP_MCLR   = 8'h34;
  localparam logic [7:0] OFS_EP_PEND   = 8'h38;
  localparam logic [7:0] OFS_CO_SRC    = 8'h40;
  localparam logic [7:0] OFS_CO_SSET   = 8'h44;
  localparam logic [7:0] OFS_CO_SCLR   = 8'h48;
  localparam logic [7:0] OFS_CO_MSK    = 8'h4C;
  localparam logic [7:0] OFS_CO_MSET   = 8'h50;
  localparam logic [7:0] OFS_CO_MCLR   = 8'h54;
  localparam logic [7:0] OFS_CO_PEND   = 8'h58;
  localparam logic [7:0] OFS_EOI       = 8'h60;

  // Next value of a sticky bit vector: host set, then host clear, then
  // hardware set on top so a hardware event survives a same-cycle clear.
  function automatic word_t sticky_next(word_t cur, word_t set_b, word_t clr_b,
                                        word_t hw_b, word_t impl);
    return (((cur | set_b) & ~clr_b) | hw_b) & impl;
  endfunction

  // Data carried by an alias write: the write data when the offset hits.
  function automatic word_t alias_bits(logic hit, word_t data);
    return hit ? data : '0;
  endfunction
endpackage

// File: rtl/irq_group.sv
module irq_group
  import usb_irq_pkg::*;
#(
  parameter int          W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] src_set,
  input  logic [W-1:0] src_clr,
  input  logic [W-1:0] msk_set,
  input  logic [W-1:0] msk_clr,
  output logic [W-1:0] src,
  output logic [W-1:0] msk,
  output logic [W-1:0] pend
);
  localparam word_t IMPL_W = word_t'(IMPL);

  logic [W-1:0] src_d, msk_d;

  always_comb begin
    src_d = W'(sticky_next(word_t'(src), word_t'(src_set), word_t'(src_clr),
                           word_t'(hw_set), IMPL_W));
    msk_d = W'(sticky_next(word_t'(msk), word_t'(msk_set), word_t'(msk_clr),
                           '0, IMPL_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      msk <= '0;
    end else if (srst) begin
      src <= '0;
      msk <= '0;
    end else begin
      src <= src_d;
      msk <= msk_d;
    end
  end

  assign pend = src & msk;
endmodule

// File: rtl/irq_arm.sv
module irq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic eoi,
  input  logic srst,
  output logic irq,
  output logic armed
);
  logic fire;
  assign fire = armed & pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      irq <= pending & (irq | armed);
      if (srst || eoi)  armed <= 1'b1;
      else if (fire)    armed <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usb_irq_pkg::*;
#(
  parameter int    TX_EPS    = 16,
  parameter int    RX_EPS    = 16,
  parameter int    CORE_EVTS = 9,
  parameter int    CORE_LSB  = 16,
  parameter word_t REV_ID    = 32'h0002_0001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [TX_EPS-1:0]    ep_tx_evt,
  input  logic [RX_EPS-1:0]    ep_rx_evt,
  input  logic [CORE_EVTS-1:0] core_evt,
  input  logic                 vbus_drv_lvl,
  output logic                 irq_o
);
  localparam int EP_W = TX_EPS + RX_EPS;
  localparam logic [EP_W-1:0] EP_IMPL = ~(EP_W'(1) << TX_EPS);

  // named internal events
  logic                 srst_wr, eoi_wr, armed, pending;
  logic [EP_W-1:0]      ep_hw_set, ep_src, ep_msk, ep_pend;
  logic [CORE_EVTS-1:0] core_src, core_msk, core_pend;

  function automatic logic hit(logic [7:0] ofs);
    return bus_wr && (bus_addr == ofs);
  endfunction

  assign srst_wr   = hit(OFS_CTRL) && bus_wdata[0];
  assign eoi_wr    = hit(OFS_EOI);
  assign ep_hw_set = {ep_rx_evt, ep_tx_evt};
  assign pending   = (|ep_pend) | (|core_pend);

  irq_group #(.W(EP_W), .IMPL(EP_IMPL)) u_ep (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_wr),
    .hw_set  (ep_hw_set),
    .src_set (EP_W'(alias_bits(hit(OFS_EP_SSET), bus_wdata))),
    .src_clr (EP_W'(alias_bits(hit(OFS_EP_SCLR), bus_wdata))),
    .msk_set (EP_W'(alias_bits(hit(OFS_EP_MSET), bus_wdata))),
    .msk_clr (EP_W'(alias_bits(hit(OFS_EP_MCLR), bus_wdata))),
    .src     (ep_src),
    .msk     (ep_msk),
    .pend    (ep_pend)
  );

  irq_group #(.W(CORE_EVTS)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_wr),
    .hw_set  (core_evt),
    .src_set (CORE_EVTS'(alias_bits(hit(OFS_CO_SSET), bus_wdata) >> CORE_LSB)),
    .src_clr (CORE_EVTS'(alias_bits(hit(OFS_CO_SCLR), bus_wdata) >> CORE_LSB)),
    .msk_set (CORE_EVTS'(alias_bits(hit(OFS_CO_MSET), bus_wdata) >> CORE_LSB)),
    .msk_clr (CORE_EVTS'(alias_bits(hit(OFS_CO_MCLR), bus_wdata) >> CORE_LSB)),
    .src     (core_src),
    .msk     (core_msk),
    .pend    (core_pend)
  );

  irq_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (pending),
    .eoi     (eoi_wr),
    .srst    (srst_wr),
    .irq     (irq_o),
    .armed   (armed)
  );

  always_comb begin
    case (bus_addr)
      OFS_REV:     bus_rdata = REV_ID;
      OFS_STAT:    bus_rdata = word_t'(vbus_drv_lvl);
      OFS_EP_SRC:  bus_rdata = word_t'(ep_src);
      OFS_EP_MSK:  bus_rdata = word_t'(ep_msk);
      OFS_EP_PEND: bus_rdata = word_t'(ep_pend);
      OFS_CO_SRC:  bus_rdata = word_t'(core_src) << CORE_LSB;
      OFS_CO_MSK:  bus_rdata = word_t'(core_msk) << CORE_LSB;
      OFS_CO_PEND: bus_rdata = word_t'(core_pend) << CORE_LSB;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk #(
  parameter int EP_W   = 32,
  parameter int CORE_W = 9,
  parameter int HOLE   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              armed,
  input logic              pending,
  input logic              eoi_wr,
  input logic              srst_wr,
  input logic [EP_W-1:0]   ep_hw_set,
  input logic [EP_W-1:0]   ep_src,
  input logic [EP_W-1:0]   ep_msk,
  input logic [CORE_W-1:0] core_src,
  input logic [CORE_W-1:0] core_msk
);
  a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(pending));

  a_r9_no_fire_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !irq_o) |=> !irq_o);

  a_r9_eoi_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> armed);

  a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (ep_src == '0 && ep_msk == '0 && core_src == '0 && core_msk == '0));

  a_r6_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_src[HOLE] && !ep_msk[HOLE]);

  a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_wr && ep_hw_set[0]) |=> ep_src[0]);
endmodule

bind usb_irq_wrap usb_irq_wrap_chk #(.EP_W(EP_W), .CORE_W(CORE_EVTS), .HOLE(TX_EPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .armed     (armed),
  .pending   (pending),
  .eoi_wr    (eoi_wr),
  .srst_wr   (srst_wr),
  .ep_hw_set (ep_hw_set),
  .ep_src    (ep_src),
  .ep_msk    (ep_msk),
  .core_src  (core_src),
  .core_msk  (core_msk)
);

// File: tb/usb_irq_wrap_tb.sv
`timescale 1ns/1ps
module usb_irq_wrap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] ep_tx_evt = '0;
  logic [15:0] ep_rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_drv_lvl = 1'b0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  usb_irq_wrap u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_tx_evt(ep_tx_evt),
    .ep_rx_evt(ep_rx_evt), .core_evt(core_evt), .vbus_drv_lvl(vbus_drv_lvl),
    .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(logic [15:0] tx, logic [15:0] rx, logic [8:0] co);
    @(negedge clk);
    ep_tx_evt = tx; ep_rx_evt = rx; core_evt = co;
    @(negedge clk);
    ep_tx_evt = '0; ep_rx_evt = '0; core_evt = '0;
  endtask

  task automatic tidy();
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h60, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 irq after reset", 32'(irq_o), 32'h0);
    rd("R1 revision", 8'h00, 32'h0002_0001);
    rd("R1 ep src", 8'h20, 32'h0);
    rd("R1 ep mask", 8'h2C, 32'h0);
    rd("R1 core src", 8'h40, 32'h0);
    rd("R1 core mask", 8'h4C, 32'h0);
    rd("R12 reserved 0x10", 8'h10, 32'h0);
  endtask

  task automatic t_src_alias();
    wr(8'h24, 32'h0001_0005);
    rd("R2/R6 ep set with hole", 8'h20, 32'h0000_0005);
    wr(8'h24, 32'h0000_0002);
    rd("R2 zero bits keep", 8'h20, 32'h0000_0007);
    wr(8'h28, 32'h0000_0001);
    rd("R3 ep clear", 8'h20, 32'h0000_0006);
    wr(8'h44, 32'hFFFF_FFFF);
    rd("R7 core layout", 8'h40, 32'h01FF_0000);
    wr(8'h48, 32'h0000_FFFF);
    rd("R3 core clear outside field", 8'h40, 32'h01FF_0000);
    wr(8'h48, 32'h00FF_0000);
    rd("R3 core clear", 8'h40, 32'h0100_0000);
    tidy();
  endtask

  task automatic t_mask();
    wr(8'h30, 32'hFFFF_FFFF);
    rd("R4/R6 ep mask set", 8'h2C, 32'hFFFE_FFFF);
    wr(8'h34, 32'hFFFF_0000);
    rd("R4 ep mask clear", 8'h2C, 32'h0000_FFFF);
    wr(8'h24, 32'h0003_0006);
    rd("R5 ep masked", 8'h38, 32'h0000_0006);
    wr(8'h50, 32'h0005_0000);
    wr(8'h44, 32'h0006_0000);
    rd("R4 core mask", 8'h4C, 32'h0005_0000);
    rd("R5 core masked", 8'h58, 32'h0004_0000);
    tidy();
  endtask

  task automatic t_hw_events();
    pulse(16'h0000, 16'h0001, 9'h000);
    rd("R6 rx ep0 ignored", 8'h20, 32'h0);
    pulse(16'h8000, 16'h0002, 9'h100);
    rd("R8 ep pulses", 8'h20, 32'h0002_8000);
    rd("R7 vbus event bit 24", 8'h40, 32'h0100_0000);
    // same-cycle hardware set and host clear of bit 3
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h0000_0008; ep_tx_evt = 16'h0008;
    @(negedge clk);
    bus_wr = 1'b0; ep_tx_evt = '0;
    rd("R8 hw set beats clear", 8'h20, 32'h0002_8008);
    tidy();
  endtask

  task automatic t_irq();
    wr(8'h30, 32'h0000_0001);
    pulse(16'h0001, 16'h0, 9'h0);
    check("R9 irq not yet", 32'(irq_o), 32'h0);
    @(negedge clk);
    check("R9 irq rises", 32'(irq_o), 32'h1);
    wr(8'h28, 32'h0000_0001);
    @(negedge clk);
    check("R9 irq drops", 32'(irq_o), 32'h0);
    pulse(16'h0001, 16'h0, 9'h0);
    repeat (3) @(negedge clk);
    check("R9 stays low until eoi", 32'(irq_o), 32'h0);
    wr(8'h60, 32'h0000_DEAD);
    @(negedge clk);
    check("R9 eoi rearms", 32'(irq_o), 32'h1);
    tidy();
    wr(8'h50, 32'h0100_0000);
    pulse(16'h0, 16'h0, 9'h100);
    @(negedge clk);
    check("R9 core irq", 32'(irq_o), 32'h1);
    rd("R5 core masked vbus", 8'h58, 32'h0100_0000);
    tidy();
  endtask

  task automatic t_soft_reset();
    wr(8'h30, 32'h0000_0010);
    wr(8'h50, 32'h0001_0000);
    wr(8'h44, 32'h0001_0000);
    wr(8'h24, 32'h0000_0010);
    @(negedge clk);
    check("R10 irq before", 32'(irq_o), 32'h1);
    wr(8'h04, 32'h0000_0001);
    rd("R10 ep src", 8'h20, 32'h0);
    rd("R10 ep mask", 8'h2C, 32'h0);
    rd("R10 core src", 8'h40, 32'h0);
    rd("R10 core mask", 8'h4C, 32'h0);
    rd("R10 ctrl reads zero", 8'h04, 32'h0);
    @(negedge clk);
    check("R10 irq low", 32'(irq_o), 32'h0);
    wr(8'h30, 32'h0000_0002);
    pulse(16'h0002, 16'h0, 9'h0);
    @(negedge clk);
    check("R10 rearmed without eoi", 32'(irq_o), 32'h1);
    tidy();
  endtask

  task automatic t_status_reserved();
    vbus_drv_lvl = 1'b1;
    rd("R11 vbus high", 8'h08, 32'h1);
    vbus_drv_lvl = 1'b0;
    rd("R11 vbus low", 8'h08, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    rd("R12 reserved 0x5C", 8'h5C, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd("R12 raw ep src ro", 8'h20, 32'h0);
    rd("R12 raw ep mask ro", 8'h2C, 32'h0);
    rd("R12 raw core src ro", 8'h40, 32'h0);
    check("R12 irq quiet", 32'(irq_o), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_src_alias();
    t_mask();
    t_hw_events();
    t_irq();
    t_soft_reset();
    t_status_reserved();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule